// File: doc/BRIEF.md
# Dual-Address DMA Transfer Engine

This block is the datapath of one DMA channel. It copies a run of 64-bit double words from a source address to a destination address. The data passes through a private staging FIFO that holds eight double words. The engine issues read requests on one request/acknowledge port and write requests on a second one. Each request carries an address, a length in double words and a burst flag. After a read is acknowledged, the memory returns exactly that many data beats. After a write is acknowledged, the memory pulls exactly that many beats.

A transfer starts on a one-cycle `start` pulse. At that pulse the engine latches the addresses, the byte count and the per-transfer options. There are four options: a source burst inhibit, a destination burst inhibit, a byte-reversal request, and a flag that says whether byte reversal is allowed for this transfer. The engine splits the work into pieces. No request crosses a 64-byte boundary of its own address. When the source and destination offsets within 64 bytes differ, reads and writes therefore break at different points. Data can then sit in the FIFO between pieces. For this reason the FIFO counts as owned by the channel for the whole transfer. When the last double word has been written, the engine raises `done` for one cycle.

Top module: `dma_dual_mover`

## Requirements
- R1: After reset, `rd_req`, `wr_req`, `done` and `fifo_owned` are all low.
- R2: With both inhibits clear, a 64-byte-aligned source region is fetched by one burst read of 8 double words (`rd_burst`=1, `rd_len`=8), and a 64-byte-aligned destination region is stored by one burst write of 8. Each acknowledged request advances its address by 8 bytes times its length, so a full burst advances it by 64 bytes.
- R3: With the source inhibit set, every read request is a single (`rd_burst`=0, `rd_len`=1), and successive read addresses step by 8 bytes.
- R4: With the destination inhibit set, every write request is a single (`wr_burst`=0, `wr_len`=1), and successive write addresses step by 8 bytes.
- R5: The two inhibits are independent. Source bursts of 8 can run in the same transfer as single writes.
- R6: No read or write request crosses a 64-byte boundary: address bits [5:3] plus the length never exceed 8. This holds even when the source and destination offsets differ.
- R7: The destination receives the source double words in their original order, at consecutive addresses starting at the destination address.
- R8: When byte reversal is requested and allowed, byte k of each written double word is byte 7-k of the read double word. For example, 0x0123456789ABCDEF is written as 0xEFCDAB8967452301.
- R9: When byte reversal is requested but not allowed, the request is ignored and data is written unchanged.
- R10: `fifo_owned` is high from the accepted `start` until `done`. The FIFO never takes a beat while it holds 8 double words, and `fifo_owned` is high whenever the FIFO holds data.
- R11: `done` is a single-cycle pulse. It is raised once, after the last write beat, when the remaining byte count is zero and the FIFO is empty.
- R12: A request holds its address and length until it is acknowledged, and `rd_req` and `wr_req` are never high together.
- R13: A `start` pulse that arrives while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| src_addr | input | AW | Source byte address, 8-byte aligned |
| dst_addr | input | AW | Destination byte address, 8-byte aligned |
| xfer_bytes | input | CW | Byte count, a multiple of 8 |
| src_inhibit | input | 1 | Issue reads as 8-byte singles |
| dst_inhibit | input | 1 | Issue writes as 8-byte singles |
| swap_req | input | 1 | Request byte reversal |
| swap_ok | input | 1 | Byte reversal allowed for this transfer |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_len | output | 4 | Read length in double words (1..8) |
| rd_burst | output | 1 | Read is a burst |
| rd_ack | input | 1 | Read request accepted |
| rd_valid | input | 1 | Read data beat |
| rd_data | input | 64 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_len | output | 4 | Write length in double words (1..8) |
| wr_burst | output | 1 | Write is a burst |
| wr_ack | input | 1 | Write request accepted |
| wr_ready | input | 1 | Memory takes a write beat |
| wr_data | output | 64 | Write data (head of FIFO, optionally byte reversed) |
| fifo_owned | output | 1 | FIFO held by this channel |
| done | output | 1 | Transfer complete pulse |

## Verification
The assertions assume the memory side follows the handshake. It raises `rd_ack` or `wr_ack` only while the matching request is high. It delivers `rd_valid` beats, or raises `wr_ready`, only after the acknowledge, and exactly as many beats as the acknowledged length. It also assumes addresses and byte counts are multiples of 8. The bench's responders model exactly this behaviour. Each one waits for a request, acknowledges it for one cycle, and then moves precisely `len` beats on the following cycles. Every transfer the bench starts uses 8-byte-aligned addresses and byte counts that are multiples of 8.

// File: rtl/dma_dual_mover.sv
module dma_dual_mover #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] xfer_bytes,
  input  logic          src_inhibit,
  input  logic          dst_inhibit,
  input  logic          swap_req,
  input  logic          swap_ok,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [3:0]    rd_len,
  output logic          rd_burst,
  input  logic          rd_ack,
  input  logic          rd_valid,
  input  logic [63:0]   rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [3:0]    wr_len,
  output logic          wr_burst,
  input  logic          wr_ack,
  input  logic          wr_ready,
  output logic [63:0]   wr_data,
  output logic          fifo_owned,
  output logic          done
);
  localparam int DEPTH = 8;
  localparam int DWC   = CW - 3;

  typedef enum logic [2:0] {IDLE, PLAN, RREQ, RDAT, WREQ, WDAT} state_t;
  state_t state;

  logic [AW-1:0]  sa, da;
  logic [CW-1:0]  bytes_left;
  logic [DWC-1:0] rd_left;
  logic [3:0]     plen, beats, cnt;
  logic [2:0]     wp, rp;
  logic           s_inh, d_inh, rev;
  logic [63:0]    mem [DEPTH];

  logic [3:0] rd_room, rd_cap, rd_free, rpiece;
  logic [3:0] wr_room, wr_cap, wpiece;
  logic [DWC-1:0] wr_dw;
  logic push, pop;

  assign push = (state == RDAT) && rd_valid;
  assign pop  = (state == WDAT) && wr_ready;

  assign wr_dw   = bytes_left[CW-1:3];
  assign rd_room = 4'(DEPTH) - {1'b0, sa[5:3]};
  assign wr_room = 4'(DEPTH) - {1'b0, da[5:3]};
  assign rd_cap  = (rd_left >= DWC'(DEPTH)) ? 4'(DEPTH) : rd_left[3:0];
  assign wr_cap  = (wr_dw   >= DWC'(DEPTH)) ? 4'(DEPTH) : wr_dw[3:0];
  assign rd_free = 4'(DEPTH) - cnt;

  always_comb begin
    rpiece = rd_cap;
    if (rd_room < rpiece) rpiece = rd_room;
    if (rd_free < rpiece) rpiece = rd_free;
    if (s_inh) rpiece = 4'd1;
    wpiece = (wr_cap < wr_room) ? wr_cap : wr_room;
    if (d_inh) wpiece = 4'd1;
  end

  assign rd_req     = (state == RREQ);
  assign rd_addr    = sa;
  assign rd_len     = plen;
  assign rd_burst   = !s_inh;
  assign wr_req     = (state == WREQ);
  assign wr_addr    = da;
  assign wr_len     = plen;
  assign wr_burst   = !d_inh;
  assign fifo_owned = (state != IDLE);

  always_comb begin
    for (int k = 0; k < 8; k++)
      wr_data[8*k +: 8] = rev ? mem[rp][8*(7-k) +: 8] : mem[rp][8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; sa <= '0; da <= '0; bytes_left <= '0; rd_left <= '0;
      plen <= 4'd1; beats <= '0; cnt <= '0; wp <= '0; rp <= '0;
      s_inh <= 1'b0; d_inh <= 1'b0; rev <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (push) wp <= wp + 3'd1;
      if (pop)  rp <= rp + 3'd1;
      cnt <= cnt + {3'd0, push} - {3'd0, pop};
      case (state)
        IDLE: if (start) begin
          sa <= src_addr; da <= dst_addr; bytes_left <= xfer_bytes;
          rd_left <= xfer_bytes[CW-1:3];
          s_inh <= src_inhibit; d_inh <= dst_inhibit; rev <= swap_req & swap_ok;
          state <= PLAN;
        end
        PLAN: begin
          if (bytes_left == '0) begin
            done <= 1'b1; state <= IDLE;
          end else if (cnt >= wpiece) begin
            plen <= wpiece; state <= WREQ;
          end else begin
            plen <= rpiece; state <= RREQ;
          end
        end
        RREQ: if (rd_ack) begin
          sa <= sa + AW'({plen, 3'b000});
          rd_left <= rd_left - DWC'(plen);
          beats <= plen; state <= RDAT;
        end
        RDAT: if (rd_valid) begin
          beats <= beats - 4'd1;
          if (beats == 4'd1) state <= PLAN;
        end
        WREQ: if (wr_ack) begin
          da <= da + AW'({plen, 3'b000});
          beats <= plen; state <= WDAT;
        end
        WDAT: if (wr_ready) begin
          bytes_left <= bytes_left - CW'(8);
          beats <= beats - 4'd1;
          if (beats == 4'd1) state <= PLAN;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assert_one_side_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr) && $stable(rd_len));
  assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_len));
  assert_rd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_burst |-> rd_len == 4'd1);
  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_burst |-> wr_len == 4'd1);
  assert_rd_no_cross_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ({2'b00, rd_addr[5:3]} + {1'b0, rd_len}) <= 5'd8);
  assert_wr_no_cross_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ({2'b00, wr_addr[5:3]} + {1'b0, wr_len}) <= 5'd8);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt < 4'(DEPTH));
  assert_held_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 4'd0 |-> fifo_owned);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt == 4'd0 && !fifo_owned);
endmodule

// File: tb/dma_dual_mover_test.sv
module dma_dual_mover_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, src_inhibit = 0, dst_inhibit = 0, swap_req = 0, swap_ok = 0;
  logic [31:0] src_addr = 0, dst_addr = 0;
  logic [15:0] xfer_bytes = 0;
  logic rd_req, rd_burst, rd_ack = 0, rd_valid = 0;
  logic [31:0] rd_addr, wr_addr;
  logic [3:0] rd_len, wr_len;
  logic [63:0] rd_data = 0, wr_data;
  logic wr_req, wr_burst, wr_ack = 0, wr_ready = 0, fifo_owned, done;

  always #4 clk = ~clk;

  dma_dual_mover uut (.*);

  int checks = 0, fails = 0;
  logic [63:0] exp_data_q[$];
  logic [31:0] exp_rd_next, exp_wr_next;
  int exp_rlen = 0, exp_wlen = 0;
  logic cur_sinh = 0, cur_dinh = 0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] src_dw(logic [31:0] a);
    if (a == 32'h3000) return 64'h0123456789ABCDEF;
    return {a ^ 32'h5A5A0F0F, ~a};
  endfunction

  function automatic logic [63:0] bswap(logic [63:0] d);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = d[8*(7-k) +: 8];
    return r;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %h expected %h", 64'd1, 64'd0);
    finish_run();
  end

  // read memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        logic [31:0] a; int n;
        a = rd_addr; n = int'(rd_len);
        check(a == exp_rd_next, "R2/R3 read address", a, exp_rd_next);
        check(rd_burst == !cur_sinh, "R3/R5 read burst flag", rd_burst, !cur_sinh);
        if (cur_sinh) check(n == 1, "R3 single read len", n, 1);
        if (exp_rlen != 0 && !cur_sinh) check(n == exp_rlen, "R2/R5 read len", n, exp_rlen);
        check(a[5:3] + n <= 8, "R6 read boundary", a[5:3] + n, 8);
        check(!wr_req && fifo_owned, "R12/R10 read exclusive", {wr_req, fifo_owned}, 2'b01);
        exp_rd_next = a + 32'(8 * n);
        rd_ack = 1;
        for (int i = 0; i < n; i++) begin
          @(negedge clk);
          rd_ack = 0; rd_valid = 1; rd_data = src_dw(a + 32'(8 * i));
        end
        @(negedge clk);
        rd_valid = 0;
      end
    end
  end

  // write memory responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (wr_req) begin
        logic [31:0] a; int n;
        a = wr_addr; n = int'(wr_len);
        check(a == exp_wr_next, "R7 write address", a, exp_wr_next);
        check(wr_burst == !cur_dinh, "R4/R5 write burst flag", wr_burst, !cur_dinh);
        if (cur_dinh) check(n == 1, "R4 single write len", n, 1);
        if (exp_wlen != 0 && !cur_dinh) check(n == exp_wlen, "R2 write len", n, exp_wlen);
        check(a[5:3] + n <= 8, "R6 write boundary", a[5:3] + n, 8);
        exp_wr_next = a + 32'(8 * n);
        wr_ack = 1;
        for (int i = 0; i < n; i++) begin
          @(negedge clk);
          wr_ack = 0; wr_ready = 1;
          if (exp_data_q.size() == 0) check(0, "R7 unexpected beat", wr_data, 0);
          else begin
            logic [63:0] e;
            e = exp_data_q.pop_front();
            check(wr_data == e, "R7/R8/R9 write data", wr_data, e);
          end
        end
        @(negedge clk);
        wr_ready = 0;
      end
    end
  end

  task automatic run_xfer(logic [31:0] s, logic [31:0] d, logic [15:0] nb,
                          logic si, logic di, logic sr, logic so,
                          int erl, int ewl, bit poke);
    int guard;
    for (int i = 0; i < int'(nb) / 8; i++) begin
      logic [63:0] v;
      v = src_dw(s + 32'(8 * i));
      exp_data_q.push_back((sr && so) ? bswap(v) : v);
    end
    exp_rd_next = s; exp_wr_next = d; exp_rlen = erl; exp_wlen = ewl;
    cur_sinh = si; cur_dinh = di;
    @(negedge clk);
    src_addr = s; dst_addr = d; xfer_bytes = nb;
    src_inhibit = si; dst_inhibit = di; swap_req = sr; swap_ok = so; start = 1;
    @(negedge clk);
    start = 0;
    check(fifo_owned, "R10 owned after start", fifo_owned, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      src_addr = 32'h7000; dst_addr = 32'h7800; xfer_bytes = 16'd8;
      src_inhibit = ~si; swap_req = 1; swap_ok = 1; start = 1;   // R13
      @(negedge clk);
      start = 0;
    end
    guard = 0;
    while (!done && guard < 5000) begin
      check(fifo_owned, "R10 owned during transfer", fifo_owned, 1);
      @(negedge clk); guard++;
    end
    check(done, "R11 done seen", done, 1);
    check(exp_data_q.size() == 0, "R7/R13 all beats written", exp_data_q.size(), 0);
    check(!fifo_owned, "R10 released at done", fifo_owned, 0);
    @(negedge clk);
    check(!done, "R11 done single cycle", done, 0);
    repeat (3) @(negedge clk);
    check(!done && !rd_req && !wr_req, "R11/R13 quiet after done",
          {done, rd_req, wr_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!rd_req && !wr_req && !done && !fifo_owned, "R1 reset state",
          {rd_req, wr_req, done, fifo_owned}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!rd_req && !wr_req && !done && !fifo_owned, "R1 idle after reset",
          {rd_req, wr_req, done, fifo_owned}, 0);
    run_xfer(32'h1000, 32'h2000, 16'd256, 0, 0, 0, 0, 8, 8, 0);  // R2 aligned bursts
    run_xfer(32'h1100, 32'h2100, 16'd64,  1, 0, 0, 0, 0, 8, 0);  // R3 source singles
    run_xfer(32'h1200, 32'h2200, 16'd128, 0, 1, 0, 0, 8, 0, 0);  // R4 R5 burst reads, single writes
    run_xfer(32'h1018, 32'h2028, 16'd200, 0, 0, 0, 0, 0, 0, 0);  // R6 unequal offsets
    run_xfer(32'h1238, 32'h2408, 16'd96,  1, 0, 0, 0, 0, 0, 0);  // R6 R3 mixed
    run_xfer(32'h3000, 32'h4010, 16'd72,  0, 0, 1, 1, 0, 0, 1);  // R8 reversal, R13 poke
    run_xfer(32'h3000, 32'h4100, 16'd32,  0, 1, 1, 0, 0, 0, 0);  // R9 reversal refused
    run_xfer(32'h5008, 32'h6030, 16'd8,   1, 1, 0, 0, 0, 0, 0);  // R3 R4 single dword
    finish_run();
  end
endmodule